// File: doc/BRIEF.md
# Prioritized Memory Protection Region Checker

This block decides, for every bus access, whether the access may proceed. It keeps a table of sixteen programmable protection regions. Each region has a power-of-two size, a base address aligned to that size, a three-bit permission code, an execute-never flag and an eight-bit mask that disables subregions. An access arrives with an address, an access kind (read, write or instruction fetch) and a privilege flag. One clock cycle later the block reports which region won and whether the access is allowed or must fault.

Regions may overlap or nest. Where they do, the matching region with the highest number supplies all attributes. The priority order is fixed. An address that no enabled region covers falls back to a default region. The default region is reported with the identifier -1 and follows a programmable rule for privileged accesses. A single register-write port loads the region entries and a global control word. While the global enable is clear, the block allows every access and applies no attributes.

Top module: `prot_region_guard`

## Requirements
- R1: Writing with `cfg_we` at `cfg_addr` 0 to 15 loads that region entry from `cfg_wdata`, with these fields: [31:0] base, [37:32] log2 of the size, [40:38] permission code, [41] execute-never, [49:42] subregion-disable mask, [50] region enable. Writing at `cfg_addr` 16 loads the global control word: bit 0 is the checking enable and bit 1 is the default-map enable. A region whose enable bit is 0 never matches.
- R2: Each access with `acc_valid` high produces exactly one result with `res_valid` high on the next clock cycle. No result appears without an access.
- R3: A region covers an address when the address bits at and above the log2 size equal the same bits of the base. The low bits of the base are ignored. Size codes below 5 act as 5, and codes of 32 or more cover the whole 4 GiB space.
- R4: When several enabled regions match an address, the highest-numbered one wins and is reported on `res_region` with `res_hit` high.
- R5: In an overlapped area only the winning region's attributes apply. A write is refused when the winner is read-only, even if a lower-numbered matching region would allow the write.
- R6: A region of 256 bytes or more is split into eight equal subregions. Subregion k is selected by the three address bits just below the log2 size, and mask bit k set removes it from the match. The lookup then falls through to the next lower-numbered matching region, or to the default region.
- R7: For regions smaller than 256 bytes the subregion mask has no effect.
- R8: The permission codes are as follows. Read covers both reads and fetches.
  - 0 and 4: no access for anyone.
  - 1: privileged read/write only.
  - 2: privileged read/write, unprivileged read-only.
  - 3: read/write for everyone.
  - 5: privileged read-only.
  - 6 and 7: read-only for everyone.
- R9: An instruction fetch (`acc_type` 2) that hits an execute-never region faults. The execute-never flag has no effect on reads (`acc_type` 0 or 3) or writes (`acc_type` 1).
- R10: With checking enabled and no region matching, `res_hit` is 0 and `res_region` is -1 (all ones). A privileged access is allowed only if the default-map enable is set. An unprivileged access always faults.
- R11: With the checking enable clear, every access is allowed, with `res_hit` 0 and `res_region` -1.
- R12: After reset all regions are disabled, both global bits are clear and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Region index 0..15, or 16 for the global control word |
| cfg_wdata | input | 51 | Region entry or global control word |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_priv | input | 1 | Access is privileged |
| res_valid | output | 1 | Result for the access of the previous cycle |
| res_hit | output | 1 | A numbered region won |
| res_region | output | 5 | Winning region number, or all ones for the default region |
| res_allow | output | 1 | Access allowed (0 means fault) |

## Verification
The main lookup is exercised with several kinds of address:
- Addresses inside a single region, which checks the base compare, alignment masking and each permission code on its own.
- Addresses where a read-only region nests inside a writable one, which shows that only the higher number decides.
- Addresses that land in a disabled subregion, which must fall through to an enclosing lower region, next to an address in an enabled subregion of the same region.
- Addresses just past a region's end and in unmapped space, which show the default region with and without default-map enable.

Reads, writes and fetches are repeated at the same addresses, which separates the permission code from the execute-never flag. A whole-space region and the global disable close the set.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int ADDR_W   = 32;
    localparam int SZ_W     = 6;
    localparam int AP_W     = 3;
    localparam int SUB_N    = 8;
    localparam int MIN_SZ   = 5;
    localparam int SUB_MIN  = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_kind_e;

    // Region entry; base sits in the low bits of the write word.
    typedef struct packed {
        logic              en;
        logic [SUB_N-1:0]  srd;
        logic              xn;
        logic [AP_W-1:0]   ap;
        logic [SZ_W-1:0]   sz;
        logic [ADDR_W-1:0] base;
    } rgn_cfg_t;

    localparam int CFG_W = $bits(rgn_cfg_t);

    function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] s);
        if (s < SZ_W'(MIN_SZ))       return SZ_W'(MIN_SZ);
        else if (s > SZ_W'(ADDR_W))  return SZ_W'(ADDR_W);
        else                         return s;
    endfunction

    function automatic logic ap_allows(input logic [AP_W-1:0] ap,
                                       input logic priv,
                                       input logic wr);
        logic rd_ok;
        logic wr_ok;
        case (ap)
            3'd1:    begin rd_ok = priv; wr_ok = priv; end
            3'd2:    begin rd_ok = 1'b1; wr_ok = priv; end
            3'd3:    begin rd_ok = 1'b1; wr_ok = 1'b1; end
            3'd5:    begin rd_ok = priv; wr_ok = 1'b0; end
            3'd6,
            3'd7:    begin rd_ok = 1'b1; wr_ok = 1'b0; end
            default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
        return wr ? wr_ok : rd_ok;
    endfunction

endpackage

// File: rtl/prg_region_match.sv
module prg_region_match
    import prg_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   sz_code,
    input  logic [SUB_N-1:0]  srd,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);
    logic [SZ_W-1:0] sz;
    logic            in_range;
    logic [2:0]      sub_idx;
    logic            sub_off;

    always_comb begin
        sz = clamp_sz(sz_code);
        if (sz >= SZ_W'(ADDR_W))
            in_range = 1'b1;
        else
            in_range = ((addr >> sz) == (base >> sz));
        sub_idx = 3'(addr >> (sz - SZ_W'(3)));
        sub_off = (sz >= SZ_W'(SUB_MIN)) && srd[sub_idx];
        match   = en && in_range && !sub_off;
    end
endmodule

// File: rtl/prg_priority_pick.sv
module prg_priority_pick #(
    parameter int N    = 16,
    parameter int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    match_vec,
    output logic            any,
    output logic [ID_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        // Ascending scan: a later (higher) index overwrites an earlier one.
        for (int i = 0; i < N; i++) begin
            if (match_vec[i]) begin
                any = 1'b1;
                idx = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/prg_perm_eval.sv
module prg_perm_eval
    import prg_pkg::*;
(
    input  logic            chk_en,
    input  logic            dflt_en,
    input  logic            hit,
    input  logic [AP_W-1:0] ap,
    input  logic            xn,
    input  acc_kind_e       kind,
    input  logic            priv,
    output logic            allow
);
    logic is_wr;
    logic is_fetch;

    always_comb begin
        is_wr    = (kind == ACC_WRITE);
        is_fetch = (kind == ACC_FETCH);
        if (!chk_en)
            allow = 1'b1;
        else if (hit)
            allow = ap_allows(ap, priv, is_wr) && !(is_fetch && xn);
        else
            allow = priv && dflt_en;
    end
endmodule

// File: rtl/prot_region_guard.sv
module prot_region_guard
    import prg_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ID_W        = $clog2(NUM_REGIONS),
    parameter int CA_W        = $clog2(NUM_REGIONS + 1),
    parameter int RID_W       = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_priv,
    output logic              res_valid,
    output logic              res_hit,
    output logic [RID_W-1:0]  res_region,
    output logic              res_allow
);
    localparam logic [CA_W-1:0] GLB_ADDR = CA_W'(NUM_REGIONS);

    rgn_cfg_t               cfg_q [NUM_REGIONS];
    logic                   en_q;
    logic                   dflt_q;
    logic [NUM_REGIONS-1:0] match_vec;
    logic [NUM_REGIONS-1:0] xn_vec;
    logic                   any_hit;
    logic [ID_W-1:0]        win_idx;
    rgn_cfg_t               win_cfg;
    logic                   hit_c;
    logic                   allow_c;

    // Region table and global control
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++)
                cfg_q[i] <= '0;
            en_q   <= 1'b0;
            dflt_q <= 1'b0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_REGIONS; i++)
                if (cfg_addr == CA_W'(i))
                    cfg_q[i] <= rgn_cfg_t'(cfg_wdata);
            if (cfg_addr == GLB_ADDR) begin
                en_q   <= cfg_wdata[0];
                dflt_q <= cfg_wdata[1];
            end
        end
    end

    // One comparator per region
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        prg_region_match u_match (
            .en      (cfg_q[g].en),
            .base    (cfg_q[g].base),
            .sz_code (cfg_q[g].sz),
            .srd     (cfg_q[g].srd),
            .addr    (acc_addr),
            .match   (match_vec[g])
        );
        assign xn_vec[g] = cfg_q[g].xn;
    end

    prg_priority_pick #(.N(NUM_REGIONS), .ID_W(ID_W)) u_pick (
        .match_vec (match_vec),
        .any       (any_hit),
        .idx       (win_idx)
    );

    assign win_cfg = cfg_q[win_idx];
    assign hit_c   = en_q && any_hit;

    prg_perm_eval u_perm (
        .chk_en  (en_q),
        .dflt_en (dflt_q),
        .hit     (hit_c),
        .ap      (win_cfg.ap),
        .xn      (win_cfg.xn),
        .kind    (acc_kind_e'(acc_type)),
        .priv    (acc_priv),
        .allow   (allow_c)
    );

    // Registered result
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_region <= '1;
            res_allow  <= 1'b0;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_hit    <= hit_c;
                res_region <= hit_c ? {1'b0, win_idx} : '1;
                res_allow  <= allow_c;
            end
        end
    end
endmodule

// File: rtl/prot_region_guard_chk.sv
module prot_region_guard_chk #(
    parameter int NUM_REGIONS = 16,
    parameter int ID_W        = $clog2(NUM_REGIONS),
    parameter int RID_W       = ID_W + 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   acc_valid,
    input logic [1:0]             acc_type,
    input logic                   acc_priv,
    input logic                   en_q,
    input logic [NUM_REGIONS-1:0] match_vec,
    input logic [NUM_REGIONS-1:0] xn_vec,
    input logic                   res_valid,
    input logic                   res_hit,
    input logic [RID_W-1:0]       res_region,
    input logic                   res_allow
);
    logic [1:0]             type_d;
    logic                   priv_d;
    logic                   en_d;
    logic [NUM_REGIONS-1:0] match_d;
    logic [NUM_REGIONS-1:0] xn_d;

    always_ff @(posedge clk) begin
        type_d  <= acc_type;
        priv_d  <= acc_priv;
        en_d    <= en_q;
        match_d <= match_vec;
        xn_d    <= xn_vec;
    end

    // R2: one result per access, one cycle later
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    // R4: reported region is the topmost matching one
    p_winner_top_r4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |->
            ((match_d >> res_region[ID_W-1:0]) == {{(NUM_REGIONS-1){1'b0}}, 1'b1}));

    // R9: fetch into an execute-never winner faults
    p_xn_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit && type_d == 2'd2 && xn_d[res_region[ID_W-1:0]])
            |-> !res_allow);

    // R10: nothing matched while checking -> default region id
    p_default_id_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && en_d && match_d == '0) |-> (!res_hit && res_region == '1));

    // R10: unprivileged access in the default region faults
    p_default_user_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && en_d && !res_hit && !priv_d) |-> !res_allow);

    // R11: checking off -> allowed, no region
    p_off_allows_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !en_d) |-> (res_allow && !res_hit));
endmodule

bind prot_region_guard prot_region_guard_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .ID_W        (ID_W),
    .RID_W       (RID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_type   (acc_type),
    .acc_priv   (acc_priv),
    .en_q       (en_q),
    .match_vec  (match_vec),
    .xn_vec     (xn_vec),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_region (res_region),
    .res_allow  (res_allow)
);

// File: tb/prot_region_guard_tb.sv
module prot_region_guard_tb;

    typedef struct packed {
        logic       hit;
        logic [4:0] region;
        logic       allow;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [50:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_type = '0;
    logic        acc_priv = 1'b0;
    logic        res_valid;
    logic        res_hit;
    logic [4:0]  res_region;
    logic        res_allow;

    int checks = 0;
    int failures = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;
    localparam logic [4:0] DFLT = 5'h1F;

    always #5ns clk = ~clk;

    prot_region_guard u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_priv(acc_priv), .res_valid(res_valid),
        .res_hit(res_hit), .res_region(res_region), .res_allow(res_allow)
    );

    task automatic cfg_region(input int idx, input logic [31:0] base,
                              input logic [5:0] sz, input logic [2:0] ap,
                              input logic xn, input logic [7:0] srd,
                              input logic en);
        cfg_we    = 1'b1;
        cfg_addr  = 5'(idx);
        cfg_wdata = {en, srd, xn, ap, sz, base};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_global(input logic en, input logic dflt);
        cfg_we    = 1'b1;
        cfg_addr  = 5'd16;
        cfg_wdata = {49'd0, dflt, en};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: presents one access and queues its expected result
    task automatic access(input logic [31:0] a, input logic [1:0] t,
                          input logic p, input logic eh,
                          input logic [4:0] er, input logic ea,
                          input string tag);
        exp_q.push_back('{hit: eh, region: er, allow: ea});
        tag_q.push_back(tag);
        acc_valid = 1'b1;
        acc_addr  = a;
        acc_type  = t;
        acc_priv  = p;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Monitor: compares each result with the queue head
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected result: got valid=1 expected valid=0");
            end else begin
                exp_t  e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (res_hit !== e.hit || res_region !== e.region || res_allow !== e.allow) begin
                    failures++;
                    $display("FAIL %s: got hit=%0b region=%0d allow=%0b expected hit=%0b region=%0d allow=%0b",
                             tg, res_hit, res_region, res_allow, e.hit, e.region, e.allow);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got no completion expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R12 reset: got valid=%0b expected 0", res_valid);
        end
        // R12/R11: after reset checking is off
        access(32'h2000_8010, WR, 1'b0, 1'b0, DFLT, 1'b1, "R12 reset off");

        // R1 programming
        cfg_region(0,  32'h2000_0000, 6'd16, 3'd3, 1'b0, 8'h00, 1'b1);
        cfg_region(4,  32'h2000_8000, 6'd15, 3'd6, 1'b1, 8'h00, 1'b1);
        cfg_region(1,  32'h1000_0000, 6'd12, 3'd5, 1'b0, 8'h00, 1'b1);
        cfg_region(2,  32'h1000_0000, 6'd10, 3'd3, 1'b0, 8'h04, 1'b1);
        cfg_region(15, 32'h4000_0000, 6'd5,  3'd1, 1'b0, 8'hFF, 1'b1);
        cfg_region(3,  32'h3000_0123, 6'd8,  3'd0, 1'b0, 8'h00, 1'b1);
        cfg_global(1'b1, 1'b1);

        access(32'h2000_0010, WR, 1'b0, 1'b1, 5'd0,  1'b1, "R3 R8 region0 full");
        access(32'h2000_8010, WR, 1'b1, 1'b1, 5'd4,  1'b0, "R5 R4 nested ro write");
        access(32'h2000_8010, RD, 1'b0, 1'b1, 5'd4,  1'b1, "R8 ro read user");
        access(32'h2000_8010, FE, 1'b1, 1'b1, 5'd4,  1'b0, "R9 fetch xn");
        access(32'h2000_0010, FE, 1'b1, 1'b1, 5'd0,  1'b1, "R9 fetch ok");
        access(32'h1000_0140, WR, 1'b0, 1'b1, 5'd1,  1'b0, "R6 sub off fallthrough");
        access(32'h1000_0140, RD, 1'b1, 1'b1, 5'd1,  1'b1, "R6 R8 priv ro read");
        access(32'h1000_0200, WR, 1'b0, 1'b1, 5'd2,  1'b1, "R6 sub on");
        access(32'h4000_0004, RD, 1'b1, 1'b1, 5'd15, 1'b1, "R7 small mask ignored");
        access(32'h4000_0004, RD, 1'b0, 1'b1, 5'd15, 1'b0, "R8 priv only user");
        access(32'h4000_0020, RD, 1'b1, 1'b0, DFLT,  1'b1, "R10 R3 past end priv");
        access(32'h5000_0000, RD, 1'b0, 1'b0, DFLT,  1'b0, "R10 default user");
        access(32'h2001_0000, WR, 1'b1, 1'b0, DFLT,  1'b1, "R3 region0 boundary");
        access(32'h3000_0100, RD, 1'b1, 1'b1, 5'd3,  1'b0, "R3 R8 unaligned base ap0");

        cfg_global(1'b1, 1'b0);
        access(32'h5000_0000, RD, 1'b1, 1'b0, DFLT,  1'b0, "R10 default map off");

        cfg_region(14, 32'h0000_0000, 6'd32, 3'd3, 1'b0, 8'h00, 1'b1);
        access(32'h5000_0000, RD, 1'b0, 1'b1, 5'd14, 1'b1, "R3 whole space");
        access(32'h4000_0004, RD, 1'b1, 1'b1, 5'd15, 1'b1, "R4 top wins");
        access(32'h2000_8010, WR, 1'b1, 1'b1, 5'd14, 1'b1, "R4 R5 higher rw wins");

        cfg_region(14, 32'h0000_0000, 6'd32, 3'd2, 1'b0, 8'h00, 1'b1);
        access(32'h5000_0000, WR, 1'b0, 1'b1, 5'd14, 1'b0, "R8 ap2 user write");
        access(32'h5000_0000, RD, 1'b0, 1'b1, 5'd14, 1'b1, "R8 ap2 user read");
        access(32'h5000_0000, WR, 1'b1, 1'b1, 5'd14, 1'b1, "R8 ap2 priv write");

        cfg_region(14, 32'h0000_0000, 6'd32, 3'd4, 1'b0, 8'h00, 1'b1);
        access(32'h5000_0000, RD, 1'b1, 1'b1, 5'd14, 1'b0, "R8 ap4 none");

        cfg_region(14, 32'h0000_0000, 6'd32, 3'd7, 1'b1, 8'h00, 1'b1);
        access(32'h5000_0000, WR, 1'b1, 1'b1, 5'd14, 1'b0, "R8 ap7 write");
        access(32'h5000_0000, RD, 1'b0, 1'b1, 5'd14, 1'b1, "R8 R9 ap7 read xn");

        cfg_region(14, 32'h0000_0000, 6'd32, 3'd3, 1'b0, 8'h00, 1'b0);
        access(32'h5000_0000, RD, 1'b1, 1'b0, DFLT,  1'b0, "R1 region enable off");

        cfg_global(1'b0, 1'b0);
        access(32'h2000_8010, FE, 1'b0, 1'b0, DFLT,  1'b1, "R11 global off");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2 drain: got pending=%0d valid=%0b expected 0 0",
                     exp_q.size(), res_valid);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule